// File: doc/BRIEF.md
# TDM Output Frame Packer

This block turns up to eight sampled channel words into one serial frame per conversion. When the frame start strobe arrives, it takes a snapshot of each channel's enable flag, data-valid flag and 24-bit word. It then works out which channel goes in which slot of the frame. After that, each shift strobe sends one bit out, most significant bit first, with channels taken in ascending index order.

Three output formats are offered. In the fixed time-division format every channel owns its slot, and an idle channel's slot carries zeros. In the dynamic time-division format only channels that are both enabled and valid appear, packed together with no gaps. A channel that has just been re-enabled joins the frame, in its own ordered position, only at the first frame start after its valid flag rises. In the discrete format each channel drives its own serial line, and an idle channel's line carries a zero word.

Top module: `tdm_frame_packer`

## Requirements
- R1: After reset, `serOut`, `discOut`, `frameBusy`, `frameLen`, `slotIdx` and `slotChan` are all zero.
- R2: With `fmtSel` = 2'b00 (fixed format), and likewise for the unused code 2'b11, the frame has 8 slots. Slot i carries channel i's word if that channel is enabled and valid, and 24 zero bits otherwise. `frameLen` reads 8.
- R3: With `fmtSel` = 2'b01 (dynamic format), the frame holds only the channels whose enable and valid flags are both set, in ascending channel order, with no empty slots between them. `frameLen` equals their count.
- R4: In dynamic format, a channel that is enabled but not yet valid is left out of the frame. The first frame started after its valid flag is set includes it, at its ordered position among the other channels.
- R5: With `fmtSel` = 2'b10 (discrete format), `discOut[c]` carries channel c's word over 24 shifts, or zeros if that channel is not enabled and valid. `serOut` stays low and `frameLen` reads 1.
- R6: The format, flags, slot list and words are captured at the frame start. Any change to these inputs during a frame has no effect on the frame in progress.
- R7: In dynamic format with no channel both enabled and valid, no frame starts: `frameBusy` stays low, `serOut` stays low and `frameLen` reads 0.
- R8: The frame advances one bit only on a cycle where `shiftEn` is high. Without `shiftEn`, every output holds its value. After `frameLen`×24 shifts, `frameBusy` falls and the data outputs return low.
- R9: During a frame, `slotIdx` gives the position of the slot being sent and `slotChan` gives the channel index of the word in that slot.
- R10: A frame start that arrives during a frame abandons the old frame and begins a new one from the new snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtSel | input | 2 | Output format: 00 fixed, 01 dynamic, 10 discrete, 11 fixed |
| chanEn | input | 8 | Per-channel enable (powered up) |
| chanValid | input | 8 | Per-channel data-valid flag |
| chanData | input | 8×24 | Channel words, channel c at bits [24c+23:24c] |
| frameStart | input | 1 | Frame start strobe; captures the snapshot |
| shiftEn | input | 1 | Shift strobe; advances one bit |
| serOut | output | 1 | Time-division serial data |
| discOut | output | 8 | Per-channel serial data in discrete format |
| slotIdx | output | 3 | Position of the slot being sent |
| slotChan | output | 3 | Channel index carried by the current slot |
| frameLen | output | 4 | Number of 24-bit slots in the current frame |
| frameBusy | output | 1 | High while a frame is being shifted |

## Verification
The bench targets these corner cases:
- Scattered enable patterns in dynamic format. A packer that leaves holes would shift zeros where a later channel's word belongs.
- Channels that are enabled but not valid. A design that checks only the enable would insert a stale word early.
- Input changes in the middle of a frame. A design that reads live inputs instead of its snapshot would produce a corrupted frame.
- An all-idle dynamic configuration. A design that handles this wrongly would start a frame of zero length that never ends.
- Stalled shift strobes and restarts during a frame. A design with a miscounted bit or slot counter would drop or repeat bits.

// File: rtl/tdm_pack_pkg.sv
package tdm_pack_pkg;

  typedef enum logic [1:0] {
    FMT_FIXED = 2'b00,
    FMT_DYN   = 2'b01,
    FMT_DISC  = 2'b10
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture snapshot
    logic shift;     // advance one bit
    logic slotDone;  // this shift finishes a slot
  } strobe_t;

  function automatic fmt_e decodeFmt(input logic [1:0] sel);
    case (sel)
      2'b01:   return FMT_DYN;
      2'b10:   return FMT_DISC;
      default: return FMT_FIXED;
    endcase
  endfunction

endpackage

// File: rtl/tdm_pack_mapper.sv
module tdm_pack_mapper
  import tdm_pack_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LEN_W = $clog2(NUM_CH + 1)
) (
  input  logic [1:0]                  fmtSel,
  input  logic [NUM_CH-1:0]           chanEn,
  input  logic [NUM_CH-1:0]           chanValid,
  output logic [NUM_CH-1:0][CH_W-1:0] mapOut,
  output logic [LEN_W-1:0]            lenOut
);

  logic [NUM_CH-1:0]           incl;
  logic [NUM_CH-1:0][CH_W-1:0] identMap;
  logic [NUM_CH-1:0][CH_W-1:0] packMap;
  logic [LEN_W-1:0]            packCnt;
  fmt_e                        fmt;

  assign incl = chanEn & chanValid;
  assign fmt  = decodeFmt(fmtSel);

  for (genvar g = 0; g < NUM_CH; g++) begin : gIdent
    assign identMap[g] = CH_W'(g);
  end

  // compaction: included channels fill slots from zero upward
  always_comb begin
    packCnt = '0;
    packMap = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (incl[i]) begin
        packMap[packCnt[CH_W-1:0]] = CH_W'(i);
        packCnt = packCnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (fmt)
      FMT_DYN: begin
        mapOut = packMap;
        lenOut = packCnt;
      end
      FMT_DISC: begin
        mapOut = identMap;
        lenOut = LEN_W'(1);
      end
      default: begin
        mapOut = identMap;
        lenOut = LEN_W'(NUM_CH);
      end
    endcase
  end

endmodule

// File: rtl/tdm_pack_ctrl.sv
module tdm_pack_ctrl
  import tdm_pack_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 24,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LEN_W = $clog2(NUM_CH + 1),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             shiftEn,
  input  logic [1:0]       fmtSel,
  input  logic [LEN_W-1:0] lenComb,
  output strobe_t          strb,
  output logic             busy,
  output logic [CH_W-1:0]  slotIdx,
  output fmt_e             capFmt,
  output logic [LEN_W-1:0] frameLen
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [BIT_W-1:0] bitIdx;
  logic             lastSlot;

  assign lastSlot      = (LEN_W'(slotIdx) == frameLen - 1'b1);
  assign strb.load     = frameStart;
  assign strb.shift    = busy && shiftEn && !frameStart;
  assign strb.slotDone = strb.shift && (bitIdx == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      slotIdx  <= '0;
      bitIdx   <= '0;
      frameLen <= '0;
      capFmt   <= FMT_FIXED;
    end else if (strb.load) begin
      busy     <= (lenComb != '0);
      slotIdx  <= '0;
      bitIdx   <= '0;
      frameLen <= lenComb;
      capFmt   <= decodeFmt(fmtSel);
    end else if (strb.shift) begin
      if (strb.slotDone) begin
        bitIdx <= '0;
        if (lastSlot) begin
          busy    <= 1'b0;
          slotIdx <= '0;
        end else begin
          slotIdx <= slotIdx + 1'b1;
        end
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_pack_datapath.sv
module tdm_pack_datapath
  import tdm_pack_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 24,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic                          busy,
  input  fmt_e                          capFmt,
  input  logic [CH_W-1:0]               slotIdx,
  input  logic [NUM_CH-1:0][CH_W-1:0]   mapComb,
  input  logic [NUM_CH-1:0]             chanEn,
  input  logic [NUM_CH-1:0]             chanValid,
  input  logic [NUM_CH-1:0][WORD_W-1:0] chanData,
  output logic                          serOut,
  output logic [NUM_CH-1:0]             discOut,
  output logic [CH_W-1:0]               slotChan
);

  logic [NUM_CH-1:0][WORD_W-1:0] maskIn;
  logic [NUM_CH-1:0][WORD_W-1:0] wordReg;
  logic [NUM_CH-1:0][WORD_W-1:0] discReg;
  logic [NUM_CH-1:0][CH_W-1:0]   mapReg;
  logic [WORD_W-1:0]             curWord;
  logic [CH_W-1:0]               nextSlot;

  assign nextSlot = slotIdx + 1'b1;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    // idle or not-yet-valid channels contribute zeros
    assign maskIn[g] = (chanEn[g] && chanValid[g]) ? chanData[g] : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        discReg[g] <= '0;
      end else if (strb.load) begin
        discReg[g] <= maskIn[g];
      end else if (strb.shift) begin
        discReg[g] <= {discReg[g][WORD_W-2:0], 1'b0};
      end
    end

    assign discOut[g] = busy && (capFmt == FMT_DISC) && discReg[g][WORD_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      mapReg  <= '0;
      curWord <= '0;
    end else if (strb.load) begin
      wordReg <= maskIn;
      mapReg  <= mapComb;
      curWord <= maskIn[mapComb[0]];
    end else if (strb.slotDone) begin
      curWord <= wordReg[mapReg[nextSlot]];
    end else if (strb.shift) begin
      curWord <= {curWord[WORD_W-2:0], 1'b0};
    end
  end

  assign serOut   = busy && (capFmt != FMT_DISC) && curWord[WORD_W-1];
  assign slotChan = busy ? mapReg[slotIdx] : '0;

endmodule

// File: rtl/tdm_frame_packer.sv
module tdm_frame_packer
  import tdm_pack_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int WORD_W = 24,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LEN_W = $clog2(NUM_CH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    fmtSel,
  input  logic [NUM_CH-1:0]             chanEn,
  input  logic [NUM_CH-1:0]             chanValid,
  input  logic [NUM_CH-1:0][WORD_W-1:0] chanData,
  input  logic                          frameStart,
  input  logic                          shiftEn,
  output logic                          serOut,
  output logic [NUM_CH-1:0]             discOut,
  output logic [CH_W-1:0]               slotIdx,
  output logic [CH_W-1:0]               slotChan,
  output logic [LEN_W-1:0]              frameLen,
  output logic                          frameBusy
);

  logic [NUM_CH-1:0][CH_W-1:0] mapComb;
  logic [LEN_W-1:0]            lenComb;
  strobe_t                     strb;
  fmt_e                        capFmt;
  logic [1:0]                  capFmtBits;

  assign capFmtBits = capFmt;

  tdm_pack_mapper #(.NUM_CH(NUM_CH)) i_mapper (
    .fmtSel    (fmtSel),
    .chanEn    (chanEn),
    .chanValid (chanValid),
    .mapOut    (mapComb),
    .lenOut    (lenComb)
  );

  tdm_pack_ctrl #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .shiftEn    (shiftEn),
    .fmtSel     (fmtSel),
    .lenComb    (lenComb),
    .strb       (strb),
    .busy       (frameBusy),
    .slotIdx    (slotIdx),
    .capFmt     (capFmt),
    .frameLen   (frameLen)
  );

  tdm_pack_datapath #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (frameBusy),
    .capFmt    (capFmt),
    .slotIdx   (slotIdx),
    .mapComb   (mapComb),
    .chanEn    (chanEn),
    .chanValid (chanValid),
    .chanData  (chanData),
    .serOut    (serOut),
    .discOut   (discOut),
    .slotChan  (slotChan)
  );

endmodule

// File: rtl/tdm_pack_chk.sv
module tdm_pack_chk #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LEN_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              shiftEn,
  input logic              frameBusy,
  input logic              serOut,
  input logic [NUM_CH-1:0] discOut,
  input logic [CH_W-1:0]   slotIdx,
  input logic [CH_W-1:0]   slotChan,
  input logic [LEN_W-1:0]  frameLen,
  input logic [1:0]        capFmt
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameBusy |-> (!serOut && discOut == '0));

  // R2
  fixed_identity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameBusy && capFmt == 2'b00) |-> (slotChan == slotIdx && frameLen == LEN_W'(NUM_CH)));

  // R3
  slot_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameBusy |-> (LEN_W'(slotIdx) < frameLen));

  // R5
  disc_serial_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameBusy && capFmt == 2'b10) |-> (!serOut && slotIdx == '0 && frameLen == LEN_W'(1)));

  // R6
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(frameLen));

  // R7
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameBusy |-> (frameLen != '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameBusy && !shiftEn && !frameStart) |=>
      ($stable(serOut) && $stable(discOut) && $stable(slotIdx) && frameBusy));

endmodule

bind tdm_frame_packer tdm_pack_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .shiftEn    (shiftEn),
  .frameBusy  (frameBusy),
  .serOut     (serOut),
  .discOut    (discOut),
  .slotIdx    (slotIdx),
  .slotChan   (slotChan),
  .frameLen   (frameLen),
  .capFmt     (capFmtBits)
);

// File: tb/test_tdm_frame_packer.sv
module test_tdm_frame_packer;

  localparam int NUM_CH = 8;
  localparam int WORD_W = 24;

  logic                          clk = 1'b0;
  logic                          rstN = 1'b0;
  logic [1:0]                    fmtSel = 2'b00;
  logic [NUM_CH-1:0]             chanEn = '0;
  logic [NUM_CH-1:0]             chanValid = '0;
  logic [NUM_CH-1:0][WORD_W-1:0] chanData = '0;
  logic                          frameStart = 1'b0;
  logic                          shiftEn = 1'b0;
  logic                          serOut;
  logic [NUM_CH-1:0]             discOut;
  logic [2:0]                    slotIdx;
  logic [2:0]                    slotChan;
  logic [3:0]                    frameLen;
  logic                          frameBusy;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [WORD_W-1:0] gotWord [NUM_CH];
  logic [WORD_W-1:0] gotDisc [NUM_CH];
  logic [2:0]        gotChan [NUM_CH];
  int                gotBits;

  always #4 clk = ~clk;  // 125 MHz

  tdm_frame_packer i_tdm_frame_packer (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .chanEn(chanEn), .chanValid(chanValid),
    .chanData(chanData), .frameStart(frameStart), .shiftEn(shiftEn), .serOut(serOut),
    .discOut(discOut), .slotIdx(slotIdx), .slotChan(slotChan), .frameLen(frameLen),
    .frameBusy(frameBusy)
  );

  typedef struct packed {
    logic [1:0] fmt;
    logic [7:0] en;
    logic [7:0] val;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 8'hFF, 8'hFF},
    '{2'b00, 8'hA5, 8'hFF},
    '{2'b00, 8'hFF, 8'h0F},
    '{2'b01, 8'hFF, 8'hFF},
    '{2'b01, 8'h5A, 8'hFF},
    '{2'b01, 8'h81, 8'h81},
    '{2'b01, 8'hF0, 8'h30},
    '{2'b10, 8'hFF, 8'hFF},
    '{2'b10, 8'h3C, 8'hF7},
    '{2'b11, 8'h0F, 8'hFF}
  };

  function automatic logic [WORD_W-1:0] dataOf(int c, int salt);
    return WORD_W'(((c + 1) * 24'h111111) ^ (salt * 24'h0F3C5A) ^ 24'h800001);
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic startFrame(logic [1:0] fmt, logic [7:0] en, logic [7:0] val, int salt);
    fmtSel = fmt;
    chanEn = en;
    chanValid = val;
    for (int c = 0; c < NUM_CH; c++) chanData[c] = dataOf(c, salt);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // shifts the frame out; optional mid-frame change, stall, or early stop
  task automatic collect(int changeAt, int stallAt, int stopAt);
    logic       holdBit;
    logic [2:0] holdSlot;
    gotBits = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      gotWord[c] = '0; gotDisc[c] = '0; gotChan[c] = '0;
    end
    for (int n = 0; n < NUM_CH * WORD_W + 4; n++) begin
      if (!frameBusy || n == stopAt) break;
      gotWord[slotIdx] = {gotWord[slotIdx][WORD_W-2:0], serOut};
      gotChan[slotIdx] = slotChan;
      for (int c = 0; c < NUM_CH; c++) gotDisc[c] = {gotDisc[c][WORD_W-2:0], discOut[c]};
      gotBits++;
      if (n == changeAt) begin
        chanData = ~chanData;
        chanEn = ~chanEn;
        chanValid = ~chanValid;
        fmtSel = fmtSel ^ 2'b01;
      end
      if (n == stallAt) begin
        shiftEn = 1'b0;
        holdBit = serOut;
        holdSlot = slotIdx;
        repeat (3) @(negedge clk);
        chk(serOut == holdBit && slotIdx == holdSlot && frameBusy, "R8", "stall hold",
            {serOut, slotIdx}, {holdBit, holdSlot});
      end
      shiftEn = 1'b1;
      @(negedge clk);
    end
    shiftEn = 1'b0;
  endtask

  task automatic checkFrame(logic [1:0] fmt, logic [7:0] en, logic [7:0] val, int salt);
    int len;
    string tag;
    logic [WORD_W-1:0] expW [NUM_CH];
    int expC [NUM_CH];
    len = 0;
    for (int s = 0; s < NUM_CH; s++) begin expW[s] = '0; expC[s] = 0; end
    if (fmt == 2'b01) begin
      tag = "R3";
      for (int c = 0; c < NUM_CH; c++)
        if (en[c] && val[c]) begin
          expW[len] = dataOf(c, salt); expC[len] = c; len++;
        end
    end else if (fmt == 2'b10) begin
      tag = "R5";
      len = 1;
    end else begin
      tag = "R2";
      len = NUM_CH;
      for (int c = 0; c < NUM_CH; c++) begin
        expW[c] = (en[c] && val[c]) ? dataOf(c, salt) : '0; expC[c] = c;
      end
    end
    chk(int'(frameLen) == len, tag, "frameLen", frameLen, len);
    chk(gotBits == len * WORD_W, "R8", "bit count", gotBits, len * WORD_W);
    chk(!frameBusy && !serOut, "R8", "idle after frame", {frameBusy, serOut}, 0);
    if (fmt == 2'b10) begin
      chk(gotWord[0] == '0, "R5", "serial low", gotWord[0], 0);
      for (int c = 0; c < NUM_CH; c++)
        chk(gotDisc[c] == ((en[c] && val[c]) ? dataOf(c, salt) : '0), "R5", "discrete word",
            gotDisc[c], (en[c] && val[c]) ? dataOf(c, salt) : '0);
    end else begin
      for (int s = 0; s < len; s++) begin
        chk(gotWord[s] == expW[s], tag, "slot word", gotWord[s], expW[s]);
        chk(int'(gotChan[s]) == expC[s], "R9", "slot channel", gotChan[s], expC[s]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!serOut && discOut == '0 && !frameBusy && frameLen == '0 && slotIdx == '0 && slotChan == '0,
        "R1", "reset outputs", {serOut, discOut, frameBusy, frameLen, slotIdx, slotChan}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!frameBusy && frameLen == '0, "R1", "after release", {frameBusy, frameLen}, 0);

    // vector table: R2, R3, R5
    for (int v = 0; v < NVEC; v++) begin
      startFrame(VEC[v].fmt, VEC[v].en, VEC[v].val, v + 1);
      collect(-1, -1, -1);
      checkFrame(VEC[v].fmt, VEC[v].en, VEC[v].val, v + 1);
      @(negedge clk);
    end

    // R4: woken channel 1 excluded until valid, then in its ordered slot
    startFrame(2'b01, 8'h0B, 8'h09, 20);
    collect(-1, -1, -1);
    checkFrame(2'b01, 8'h0B, 8'h09, 20);
    chk(gotChan[1] == 3'd3, "R4", "woken channel absent", gotChan[1], 3);
    startFrame(2'b01, 8'h0B, 8'h0B, 21);
    collect(-1, -1, -1);
    checkFrame(2'b01, 8'h0B, 8'h0B, 21);
    chk(gotChan[1] == 3'd1 && gotChan[2] == 3'd3, "R4", "woken channel inserted",
        {gotChan[1], gotChan[2]}, {3'd1, 3'd3});

    // R6: inputs flipped mid-frame do not disturb the frame
    startFrame(2'b01, 8'h6D, 8'hFF, 30);
    collect(40, -1, -1);
    checkFrame(2'b01, 8'h6D, 8'hFF, 30);
    chk(1'b1, "R6", "snapshot frame done", 0, 0);

    // R8: stalled shift in the middle of a fixed frame
    startFrame(2'b00, 8'hFF, 8'hFF, 40);
    collect(-1, 57, -1);
    checkFrame(2'b00, 8'hFF, 8'hFF, 40);

    // R7: dynamic with nothing active emits no frame
    startFrame(2'b01, 8'h00, 8'hFF, 50);
    chk(!frameBusy && !serOut && frameLen == '0, "R7", "empty dynamic",
        {frameBusy, serOut, frameLen}, 0);
    shiftEn = 1'b1;
    repeat (5) @(negedge clk);
    shiftEn = 1'b0;
    chk(!frameBusy && !serOut, "R7", "empty stays idle", {frameBusy, serOut}, 0);

    // R10: restart in mid-frame
    startFrame(2'b00, 8'hFF, 8'hFF, 60);
    collect(-1, -1, 30);
    chk(frameBusy, "R10", "first frame running", frameBusy, 1);
    startFrame(2'b01, 8'hC3, 8'hFF, 61);
    collect(-1, -1, -1);
    checkFrame(2'b01, 8'hC3, 8'hFF, 61);
    chk(gotChan[0] == 3'd0 && gotChan[3] == 3'd7, "R10", "restart slot map",
        {gotChan[0], gotChan[3]}, {3'd0, 3'd7});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule